// File: doc/BRIEF.md
# Inline Power Device Detection Controller

This block decides, for one copper Ethernet port, whether the far end is a legacy device that expects power over the cable, or an ordinary link partner that should go through normal auto-negotiation. While enabled, it starts a detection attempt by asking the analog front end for a fast link pulse (FLP) burst. It then waits a bounded number of cycles for the partner to return that burst. A returned burst marks a device that needs power. The block then reports this in a two-bit status field, raises a sticky interrupt and starts a fresh attempt. If no burst comes back before the window closes, the block reports "no device" and hands the port to auto-negotiation.

Detection and auto-negotiation never run at the same time. Once auto-negotiation is under way, the block waits for the link status flag. When an established link is later lost, the block leaves auto-negotiation and starts detecting again without outside help. Switching power onto the cable is the job of the surrounding switch logic, which reads the status field and the interrupt.

The controller has five named states. `PD_OFF` means disabled. `PD_ARM` is one cycle that issues the FLP request and clears the timer. `PD_WAIT` means the block is waiting for the returned burst. `PD_AN` means auto-negotiation is running with no link yet. `PD_LINK` means the link is established. The transitions are:

- **enable-on**: `PD_OFF` to `PD_ARM`.
- **armed**: `PD_ARM` to `PD_WAIT`.
- **found**: `PD_WAIT` to `PD_ARM` when a returned burst is seen.
- **expired**: `PD_WAIT` to `PD_AN` when the window runs out.
- **linked**: `PD_AN` to `PD_LINK` when link status is 1.
- **dropped**: `PD_LINK` to `PD_ARM` when link status is 0.
- **disable**: any state to `PD_OFF` when enable is low.

Top module: `pd_detect_ctrl`

## Requirements
- R1: After reset, `det_status` is 00 and `irq`, `flp_req` and `autoneg_go` are 0. Whenever `enable` is sampled low, the next cycle shows `det_status` 00 and `flp_req` and `autoneg_go` at 0. Disabling leaves `irq` unchanged.
- R2: When `enable` is sampled high in the disabled state, `flp_req` is 1 for exactly the next cycle and then 0 while the block waits for a returned burst.
- R3: A `loop_seen` pulse sampled during the wait window sets `det_status` to 01 (device needs power) in the next cycle. It also starts a new attempt, so `flp_req` is 1 in that cycle. If the window expires in the same cycle, the returned burst takes priority.
- R4: `irq` becomes 1 in the cycle after a returned burst is detected. It stays 1 until a cycle in which `status_rd` is sampled high with no new detection, and goes to 0 in the cycle after that read. A read in the same cycle as a detection leaves `irq` at 1.
- R5: If TIMEOUT_CYC wait cycles pass without a returned burst, `det_status` becomes 10 (no device) and `autoneg_go` becomes 1 in the next cycle. After TIMEOUT_CYC-1 such cycles, `autoneg_go` is still 0.
- R6: `autoneg_go` and `flp_req` are never 1 together. A `loop_seen` pulse outside the wait window changes neither `det_status` nor `irq`.
- R7: While auto-negotiation runs, `link_up` sampled high enters the link state, and `autoneg_go` stays 1 as long as the link holds.
- R8: `link_up` sampled low in the link state ends auto-negotiation. In the next cycle, `autoneg_go` is 0, `det_status` is 00 and `flp_req` is 1, which starts detection again.
- R9: `det_status` never shows the reserved code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows detection and auto-negotiation sequencing |
| loop_seen | input | 1 | One-cycle indication that the partner returned the FLP burst |
| link_up | input | 1 | Link status flag from the link monitor |
| status_rd | input | 1 | Read strobe that clears the interrupt |
| det_status | output | 2 | 00 idle, 01 device needs power, 10 no device |
| irq | output | 1 | Sticky detection interrupt |
| flp_req | output | 1 | One-cycle request to send an FLP burst |
| autoneg_go | output | 1 | High while auto-negotiation owns the port |

## Verification
Directed sequences separate the three ways a wait window can end. A returned burst arrives early, the window runs out exactly on its last cycle, or both happen in the same cycle, and each ending produces a different status code and next state. Further directed cases place a read in the same cycle as a detection, and send returned bursts while auto-negotiation is active, to show that they are ignored. Random stimulus then varies enable drops, burst arrivals, link flaps and reads, so that link loss, disabling and interrupt clearing overlap in orders the directed cases do not reach. Every cycle is compared against a reference model kept in the bench.

// File: rtl/pdd_pkg.sv
package pdd_pkg;

    typedef enum logic [2:0] {
        PD_OFF  = 3'd0,
        PD_ARM  = 3'd1,
        PD_WAIT = 3'd2,
        PD_AN   = 3'd3,
        PD_LINK = 3'd4
    } pd_state_e;

    typedef enum logic [1:0] {
        DC_IDLE    = 2'b00,
        DC_POWERED = 2'b01,
        DC_NONE    = 2'b10
    } det_code_e;

endpackage

// File: rtl/pdd_timer.sv
module pdd_timer #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/pdd_irq.sv
module pdd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (hit) begin
            irq_q <= 1'b1;
        end else if (rd) begin
            irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    // R4
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);

    // R4
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit) |=> !irq);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd) |=> irq);

endmodule

// File: rtl/pdd_fsm.sv
module pdd_fsm
    import pdd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       loop_seen,
    input  logic       link_up,
    input  logic       tmo,
    output logic       wait_run,
    output logic       hit,
    output logic [1:0] det_status,
    output logic       flp_req,
    output logic       autoneg_go
);
    pd_state_e state_q, state_d;
    det_code_e code_q;

    // Detection event: a returned burst during the wait window.
    assign hit = enable && (state_q == PD_WAIT) && loop_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = PD_OFF;
        end else begin
            unique case (state_q)
                PD_OFF:  state_d = PD_ARM;
                PD_ARM:  state_d = PD_WAIT;
                PD_WAIT: begin
                    if (loop_seen)  state_d = PD_ARM;
                    else if (tmo)   state_d = PD_AN;
                end
                PD_AN:   if (link_up)  state_d = PD_LINK;
                PD_LINK: if (!link_up) state_d = PD_ARM;
                default: state_d = PD_OFF;
            endcase
        end
    end

    always_comb begin
        flp_req    = 1'b0;
        autoneg_go = 1'b0;
        wait_run   = 1'b0;
        unique case (state_q)
            PD_OFF:  ;
            PD_ARM:  flp_req = 1'b1;
            PD_WAIT: wait_run = 1'b1;
            PD_AN:   autoneg_go = 1'b1;
            PD_LINK: autoneg_go = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= DC_IDLE;
        end else if (!enable) begin
            code_q <= DC_IDLE;
        end else if (hit) begin
            code_q <= DC_POWERED;
        end else if (state_q == PD_WAIT && tmo) begin
            code_q <= DC_NONE;
        end else if (state_q == PD_LINK && !link_up) begin
            code_q <= DC_IDLE;
        end
    end

    assign det_status = code_q;

    // R9
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_status != 2'b11);

    // R6
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(autoneg_go && flp_req));

    // R2
    flp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flp_req |=> !flp_req);

    // R5
    expire_to_an_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tmo && !loop_seen) |=> (autoneg_go && det_status == 2'b10));

    // R8
    link_drop_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == PD_LINK && !link_up) |=> (flp_req && !autoneg_go));

    // R1
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (det_status == 2'b00 && !flp_req && !autoneg_go));

endmodule

// File: rtl/pd_detect_ctrl.sv
module pd_detect_ctrl #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       loop_seen,
    input  logic       link_up,
    input  logic       status_rd,
    output logic [1:0] det_status,
    output logic       irq,
    output logic       flp_req,
    output logic       autoneg_go
);
    logic wait_run;
    logic tmo;
    logic hit;

    pdd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (tmo)
    );

    pdd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .loop_seen  (loop_seen),
        .link_up    (link_up),
        .tmo        (tmo),
        .wait_run   (wait_run),
        .hit        (hit),
        .det_status (det_status),
        .flp_req    (flp_req),
        .autoneg_go (autoneg_go)
    );

    pdd_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .rd    (status_rd),
        .irq   (irq)
    );

endmodule

// File: tb/pd_detect_ctrl_test.sv
`timescale 1ns/1ps
module pd_detect_ctrl_test;
    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, loop_seen = 1'b0, link_up = 1'b0, status_rd = 1'b0;
    logic [1:0] det_status;
    logic irq, flp_req, autoneg_go;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model: 0 off, 1 arm, 2 wait, 3 autoneg, 4 link
    int ms = 0;
    int mc = 0;
    int mstat = 0;
    bit mirq = 1'b0;

    always #2 clk = ~clk;

    pd_detect_ctrl #(.TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .loop_seen(loop_seen),
        .link_up(link_up), .status_rd(status_rd), .det_status(det_status),
        .irq(irq), .flp_req(flp_req), .autoneg_go(autoneg_go)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int exp_flp(input int s);
        return (s == 1) ? 1 : 0;
    endfunction

    function automatic int exp_an(input int s);
        return (s == 3 || s == 4) ? 1 : 0;
    endfunction

    task automatic model_edge(input bit en, input bit lb, input bit lk, input bit rd);
        bit hit, tmo;
        int ns;
        hit = en && ms == 2 && lb;
        tmo = ms == 2 && mc == TO - 1;
        mirq = hit ? 1'b1 : (rd ? 1'b0 : mirq);
        if (!en) mstat = 0;
        else if (hit) mstat = 1;
        else if (tmo) mstat = 2;
        else if (ms == 4 && !lk) mstat = 0;
        if (ms == 2) mc = tmo ? mc : mc + 1;
        else mc = 0;
        ns = ms;
        if (!en) ns = 0;
        else case (ms)
            0: ns = 1;
            1: ns = 2;
            2: ns = lb ? 1 : (tmo ? 3 : 2);
            3: ns = lk ? 4 : 3;
            4: ns = lk ? 4 : 1;
            default: ns = 0;
        endcase
        ms = ns;
    endtask

    task automatic compare_all();
        check("R3/R5/R8 status", int'(det_status), mstat);
        check("R4 irq", int'(irq), int'(mirq));
        check("R2 flp_req", int'(flp_req), exp_flp(ms));
        check("R7 autoneg_go", int'(autoneg_go), exp_an(ms));
        check("R9 reserved code", int'(det_status == 2'b11), 0);
        check("R6 exclusive", int'(flp_req && autoneg_go), 0);
    endtask

    task automatic step(input bit en, input bit lb, input bit lk, input bit rd);
        enable = en; loop_seen = lb; link_up = lk; status_rd = rd;
        @(posedge clk);
        model_edge(en, lb, lk, rd);
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d7e_a5c3));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset status", int'(det_status), 0);
        check("R1 reset irq", int'(irq), 0);
        check("R1 reset flp", int'(flp_req), 0);
        check("R1 reset an", int'(autoneg_go), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);

        // R2: enabling issues one FLP request
        step(1, 0, 0, 0);
        check("R2 flp on arm", int'(flp_req), 1);
        step(1, 0, 0, 0);
        check("R2 flp single", int'(flp_req), 0);

        // R5: window expiry boundary
        for (int k = 0; k < TO - 1; k++) step(1, 0, 0, 0);
        check("R5 no autoneg before window end", int'(autoneg_go), 0);
        step(1, 0, 0, 0);
        check("R5 autoneg after expiry", int'(autoneg_go), 1);
        check("R5 status no device", int'(det_status), 2);

        // R6: returned burst outside window ignored
        step(1, 1, 0, 0);
        check("R6 status kept", int'(det_status), 2);
        check("R6 irq untouched", int'(irq), 0);

        // R7: link established
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        check("R7 autoneg held", int'(autoneg_go), 1);

        // R8: link drop re-arms detection
        step(1, 0, 0, 0);
        check("R8 autoneg off", int'(autoneg_go), 0);
        check("R8 status idle", int'(det_status), 0);
        check("R8 flp pulse", int'(flp_req), 1);

        // R3/R4: detection
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        check("R3 status powered", int'(det_status), 1);
        check("R3 new attempt", int'(flp_req), 1);
        check("R4 irq set", int'(irq), 1);
        step(1, 0, 0, 1);
        check("R4 read clears", int'(irq), 0);
        step(1, 1, 0, 1);
        check("R4 read with hit keeps irq", int'(irq), 1);

        // R3: burst on the last window cycle wins over expiry
        step(1, 0, 0, 0);
        for (int k = 0; k < TO - 1; k++) step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        check("R3 hit beats expiry status", int'(det_status), 1);
        check("R3 hit beats expiry flp", int'(flp_req), 1);
        check("R3 hit beats expiry an", int'(autoneg_go), 0);

        // R1: disable
        step(0, 0, 0, 0);
        check("R1 disable status", int'(det_status), 0);
        check("R1 disable keeps irq", int'(irq), 1);
        check("R1 disable an", int'(autoneg_go), 0);
        step(1, 0, 0, 0);
        check("R2 re-enable flp", int'(flp_req), 1);

        // random phase
        begin
            bit lk = 1'b0;
            for (int n = 0; n < 4000; n++) begin
                bit en, lb, rd;
                en = ($urandom % 64) != 0;
                lb = ($urandom % 12) == 0;
                rd = ($urandom % 6) == 0;
                if (($urandom % 10) == 0) lk = ~lk;
                step(en, lb, lk, rd);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule